// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block controls a small on-chip flash model: an array of halfword cells held in registers. A host talks to it only through bus write cycles on an active-low write strobe (`wr_n`) with address and data lines. The block watches those strobes for two multi-cycle unlock sequences. A four-cycle sequence programs one halfword. A six-cycle sequence erases the whole array. Once a sequence is complete, the block runs an internally timed algorithm. While that algorithm runs, `busy` is high. A one-cycle `done` pulse marks a successful finish, and `fail` marks a failed program or erase that has locked the block.

Per-block protection bits keep the algorithms away from chosen address ranges. When `busy` is low, `rdata` returns the cell addressed by `addr`. A chip erase has three phases. It first clears every unprotected word to zero, then sets every unprotected word to all ones, and then checks that all those words read back as all ones. Programming can only clear bits, and asking for a 1 over a stored 0 locks the block in the failed state. Only the reset command code or a hardware reset leaves that state.

States of the algorithm machine and their transitions:
- `ST_READ` goes to `ST_PROG` on a program start, or to `ST_PROT_WAIT` when the target block is protected.
- `ST_READ` goes to `ST_PRE` on an erase start, or to `ST_ALLP_WAIT` when every block is protected.
- `ST_PROG` goes to `ST_READ` on success, or to `ST_FAIL` when the request asked for a 1 over a stored 0.
- `ST_PROT_WAIT` and `ST_ALLP_WAIT` go to `ST_READ` when their timer runs out.
- `ST_PRE` goes to `ST_ERASE`, and `ST_ERASE` goes to `ST_VERIFY`, each after walking the last word.
- `ST_VERIFY` goes to `ST_READ` after the last word, or to `ST_FAIL` on a mismatch.
- `ST_FAIL` goes to `ST_READ` on the reset command.

The command counter has its own steps, 0 to 5. Step 3 branches into the program path or the erase path, depending on the code received in step 2.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After hardware reset, `busy`, `done` and `fail` are all 0.
- R2: The program sequence has four write cycles: 0xAA at address UA1 (0x15), then 0x55 at UA2 (0x2A), then 0xA0 at UA1, then the target address and data. Codes are compared on `wdata[7:0]`. The sequence holds `busy` for exactly PROG_CYC cycles and stores old AND new in the target word. `done` is then high for one cycle, in the first cycle with `busy` low.
- R3: In the fourth program cycle, the address is taken at the falling edge of `wr_n` and the data at the rising edge. A change of `addr` while `wr_n` is low has no effect.
- R4: A program request aimed at a protected block leaves the array unchanged. It holds `busy` for exactly PROT_CYC cycles and then pulses `done` with `fail` low. Bit i of `prot` protects the block whose index is `addr[ADDR_W-1 -: log2(NBLK)]`.
- R5: A program request that asks for a 1 where the stored bit is 0 ends with `fail` = 1 and `busy` = 1, and the block stays there.
- R6: In the failed state, every write is ignored except one with code 0xF0, which returns the block to read mode with `busy` and `fail` low and no `done` pulse.
- R7: The erase sequence has six write cycles: 0xAA@UA1, 0x55@UA2, 0x80@UA1, 0xAA@UA1, 0x55@UA2, 0x10@UA1. It leaves every unprotected word at 0xFFFF and every protected word unchanged, then pulses `done`.
- R8: The erase first clears every unprotected word to 0x0000. Only after that does it set any word to all ones, walking upward from address 0.
- R9: If every block is protected, an erase changes nothing. It holds `busy` for exactly ALLP_CYC cycles and then pulses `done`.
- R10: A hardware reset stops a running algorithm at once and returns the block to read mode. A later erase then works normally.
- R11: Command writes made while an algorithm runs are ignored.
- R12: A write that does not match the expected step of a sequence sends the counter back to step 0. The writes that follow cannot complete the broken sequence.
- R13: When `busy` is low, `rdata` shows the array word at `addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_n | input | 1 | Active-low bus write strobe |
| addr | input | ADDR_W | Bus address, used for commands and reads |
| wdata | input | DATA_W | Bus write data |
| prot | input | NBLK | Protection bit per block |
| rdata | output | DATA_W | Array read data, zero while busy |
| busy | output | 1 | Algorithm running or locked after a failure |
| done | output | 1 | One-cycle pulse on successful completion |
| fail | output | 1 | Failure lock indicator |

## Verification
The hardest behaviour to observe from the ports is the preprogram phase of a chip erase. When an erase completes, every word reads 0xFFFF, and while it runs, `rdata` is held at zero. The bench therefore starts an erase with no blocks protected and counts clock cycles from the rise of `busy` to a point halfway through the set-to-ones walk. At that point it applies a hardware reset. Reading back then shows that low addresses already hold 0xFFFF while the top word still holds 0x0000, which proves both the preprogram pass and the immediate abort.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

    typedef enum logic [2:0] {
        ST_READ      = 3'd0,
        ST_PROG      = 3'd1,
        ST_PROT_WAIT = 3'd2,
        ST_FAIL      = 3'd3,
        ST_PRE       = 3'd4,
        ST_ERASE     = 3'd5,
        ST_VERIFY    = 3'd6,
        ST_ALLP_WAIT = 3'd7
    } algo_state_t;

    typedef enum logic {
        SK_PROG  = 1'b0,
        SK_ERASE = 1'b1
    } seq_kind_t;

endpackage

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wd,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rd
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Cell contents survive hardware reset, like a non-volatile array.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wd;
    end

    assign rd = cells[raddr];
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_pe_pkg::*;
#(
    parameter int              ADDR_W  = 6,
    parameter int              DATA_W  = 16,
    parameter logic [ADDR_W-1:0] UA1   = 6'h15,
    parameter logic [ADDR_W-1:0] UA2   = 6'h2A,
    parameter logic [7:0]      CODE_K1 = 8'hAA,
    parameter logic [7:0]      CODE_K2 = 8'h55,
    parameter logic [7:0]      CODE_PG = 8'hA0,
    parameter logic [7:0]      CODE_ER = 8'h80,
    parameter logic [7:0]      CODE_CH = 8'h10,
    parameter logic [7:0]      CODE_RS = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              accept_seq,
    input  logic              accept_rst,
    output logic              start_prog,
    output logic              start_erase,
    output logic              cmd_reset,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data
);
    logic              wr_q;
    logic [ADDR_W-1:0] lat_addr;
    logic [2:0]        step;
    seq_kind_t         kind;

    logic       wr_fall, wr_rise, at_ua1, at_ua2;
    logic [7:0] code;

    assign wr_fall = wr_q & ~wr_n;
    assign wr_rise = ~wr_q & wr_n;
    assign code    = wdata[7:0];
    assign at_ua1  = (lat_addr == UA1);
    assign at_ua2  = (lat_addr == UA2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q        <= 1'b1;
            lat_addr    <= '0;
            step        <= 3'd0;
            kind        <= SK_PROG;
            start_prog  <= 1'b0;
            start_erase <= 1'b0;
            cmd_reset   <= 1'b0;
            op_addr     <= '0;
            op_data     <= '0;
        end else begin
            wr_q        <= wr_n;
            start_prog  <= 1'b0;
            start_erase <= 1'b0;
            cmd_reset   <= 1'b0;
            if (wr_fall) lat_addr <= addr;
            if (wr_rise) begin
                if (accept_rst) begin
                    step <= 3'd0;
                    if (code == CODE_RS) cmd_reset <= 1'b1;
                end else if (!accept_seq) begin
                    step <= 3'd0;
                end else begin
                    unique case (step)
                        3'd0: step <= (at_ua1 && code == CODE_K1) ? 3'd1 : 3'd0;
                        3'd1: step <= (at_ua2 && code == CODE_K2) ? 3'd2 : 3'd0;
                        3'd2: begin
                            if (at_ua1 && code == CODE_PG) begin
                                step <= 3'd3;
                                kind <= SK_PROG;
                            end else if (at_ua1 && code == CODE_ER) begin
                                step <= 3'd3;
                                kind <= SK_ERASE;
                            end else begin
                                step <= 3'd0;
                            end
                        end
                        3'd3: begin
                            if (kind == SK_PROG) begin
                                start_prog <= 1'b1;
                                op_addr    <= lat_addr;
                                op_data    <= wdata;
                                step       <= 3'd0;
                            end else begin
                                step <= (at_ua1 && code == CODE_K1) ? 3'd4 : 3'd0;
                            end
                        end
                        3'd4: step <= (at_ua2 && code == CODE_K2) ? 3'd5 : 3'd0;
                        3'd5: begin
                            if (at_ua1 && code == CODE_CH) start_erase <= 1'b1;
                            step <= 3'd0;
                        end
                        default: step <= 3'd0;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/flash_algo_fsm.sv
module flash_algo_fsm
    import flash_pe_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 16,
    parameter int NBLK      = 4,
    parameter int PROG_CYC  = 4,
    parameter int PROT_CYC  = 6,
    parameter int STEP_CYC  = 2,
    parameter int ALLP_CYC  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_prog,
    input  logic              start_erase,
    input  logic              cmd_reset,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [NBLK-1:0]   prot,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic              fail
);
    localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1;
    localparam int TMR_W = $clog2(PROG_CYC + PROT_CYC + STEP_CYC + ALLP_CYC + 1);
    localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

    algo_state_t       state, nxt;
    logic [TMR_W-1:0]  tmr;
    logic [ADDR_W-1:0] widx, op_addr_q;
    logic [DATA_W-1:0] op_data_q;

    logic walk, tmr_zero, cur_prot, tgt_prot, step_fire, adv, last_word;
    logic [DATA_W-1:0] bad_bits;

    assign walk      = (state == ST_PRE) || (state == ST_ERASE) || (state == ST_VERIFY);
    assign mem_addr  = (state == ST_PROG) ? op_addr_q : widx;
    assign tmr_zero  = (tmr == '0);
    assign cur_prot  = prot[mem_addr[ADDR_W-1 -: BLK_W]];
    assign tgt_prot  = prot[prog_addr[ADDR_W-1 -: BLK_W]];
    assign step_fire = walk && !cur_prot && tmr_zero;
    assign adv       = walk && (cur_prot || tmr_zero);
    assign last_word = &widx;
    assign bad_bits  = op_data_q & ~mem_rdata;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_READ;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_READ: begin
                if (start_prog)       nxt = tgt_prot ? ST_PROT_WAIT : ST_PROG;
                else if (start_erase) nxt = (&prot) ? ST_ALLP_WAIT : ST_PRE;
            end
            ST_PROG:      if (tmr_zero) nxt = (|bad_bits) ? ST_FAIL : ST_READ;
            ST_PROT_WAIT: if (tmr_zero) nxt = ST_READ;
            ST_ALLP_WAIT: if (tmr_zero) nxt = ST_READ;
            ST_FAIL:      if (cmd_reset) nxt = ST_READ;
            ST_PRE:       if (adv && last_word) nxt = ST_ERASE;
            ST_ERASE:     if (adv && last_word) nxt = ST_VERIFY;
            ST_VERIFY: begin
                if (step_fire && mem_rdata != ONES) nxt = ST_FAIL;
                else if (adv && last_word)          nxt = ST_READ;
            end
            default: nxt = ST_READ;
        endcase
    end

    // Timer, word walker and operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr       <= '0;
            widx      <= '0;
            op_addr_q <= '0;
            op_data_q <= '0;
        end else begin
            unique case (state)
                ST_READ: begin
                    if (start_prog) begin
                        op_addr_q <= prog_addr;
                        op_data_q <= prog_data;
                        tmr <= tgt_prot ? TMR_W'(PROT_CYC - 1) : TMR_W'(PROG_CYC - 1);
                    end else if (start_erase) begin
                        widx <= '0;
                        tmr  <= (&prot) ? TMR_W'(ALLP_CYC - 1) : TMR_W'(STEP_CYC - 1);
                    end
                end
                ST_PROG, ST_PROT_WAIT, ST_ALLP_WAIT: begin
                    if (!tmr_zero) tmr <= tmr - 1'b1;
                end
                ST_PRE, ST_ERASE, ST_VERIFY: begin
                    if (adv) begin
                        widx <= widx + 1'b1;
                        tmr  <= TMR_W'(STEP_CYC - 1);
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_we    = 1'b0;
        mem_wdata = '0;
        unique case (state)
            ST_PROG: begin
                mem_we    = tmr_zero;
                mem_wdata = mem_rdata & op_data_q;
            end
            ST_PRE: begin
                mem_we    = step_fire;
                mem_wdata = '0;
            end
            ST_ERASE: begin
                mem_we    = step_fire;
                mem_wdata = ONES;
            end
            default: ;
        endcase
        busy = (state != ST_READ);
        fail = (state == ST_FAIL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (state != ST_READ) && (state != ST_FAIL) && (nxt == ST_READ);
    end
endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl #(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 16,
    parameter int NBLK     = 4,
    parameter int PROG_CYC = 4,
    parameter int PROT_CYC = 6,
    parameter int STEP_CYC = 2,
    parameter int ALLP_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NBLK-1:0]   prot,
    output logic [DATA_W-1:0] rdata,
    output logic              busy,
    output logic              done,
    output logic              fail
);
    logic              start_prog, start_erase, cmd_reset;
    logic [ADDR_W-1:0] op_addr, mem_waddr, mem_raddr;
    logic [DATA_W-1:0] op_data, mem_rd, mem_wd;
    logic              mem_we;

    flash_cmd_seq #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_n       (wr_n),
        .addr       (addr),
        .wdata      (wdata),
        .accept_seq (!busy),
        .accept_rst (fail),
        .start_prog (start_prog),
        .start_erase(start_erase),
        .cmd_reset  (cmd_reset),
        .op_addr    (op_addr),
        .op_data    (op_data)
    );

    flash_algo_fsm #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .NBLK    (NBLK),
        .PROG_CYC(PROG_CYC),
        .PROT_CYC(PROT_CYC),
        .STEP_CYC(STEP_CYC),
        .ALLP_CYC(ALLP_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_prog (start_prog),
        .start_erase(start_erase),
        .cmd_reset  (cmd_reset),
        .prog_addr  (op_addr),
        .prog_data  (op_data),
        .prot       (prot),
        .mem_rdata  (mem_rd),
        .mem_addr   (mem_waddr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wd),
        .busy       (busy),
        .done       (done),
        .fail       (fail)
    );

    assign mem_raddr = busy ? mem_waddr : addr;

    flash_cell_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_arr (
        .clk  (clk),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wd   (mem_wd),
        .raddr(mem_raddr),
        .rd   (mem_rd)
    );

    assign rdata = busy ? '0 : mem_rd;
endmodule

// File: rtl/flash_pe_ctrl_sva.sv
module flash_pe_ctrl_sva #(
    parameter int ADDR_W = 6,
    parameter int NBLK   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic              start_prog,
    input logic              start_erase,
    input logic              cmd_reset,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_waddr,
    input logic [NBLK-1:0]   prot
);
    localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1;

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_PROT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !prot[mem_waddr[ADDR_W-1 -: BLK_W]]); // R4
    AST_FAIL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> busy); // R5
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !cmd_reset) |=> fail); // R6
    AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fail) |-> !(start_prog || start_erase)); // R11
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we); // R13
endmodule

bind flash_pe_ctrl flash_pe_ctrl_sva #(
    .ADDR_W(ADDR_W),
    .NBLK  (NBLK)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .fail       (fail),
    .start_prog (start_prog),
    .start_erase(start_erase),
    .cmd_reset  (cmd_reset),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .prot       (prot)
);

// File: tb/flash_pe_ctrl_test.sv
`timescale 1ns/1ps
module flash_pe_ctrl_test;
    localparam int ADDR_W = 6, DATA_W = 16, NBLK = 4;
    localparam int PROG_CYC = 4, PROT_CYC = 6, STEP_CYC = 2, ALLP_CYC = 20;
    localparam logic [ADDR_W-1:0] UA1 = 6'h15, UA2 = 6'h2A;

    logic clk = 1'b0, rst_n = 1'b0, wr_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [NBLK-1:0]   prot = '0;
    logic [DATA_W-1:0] rdata;
    logic busy, done, fail;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    flash_pe_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBLK(NBLK), .PROG_CYC(PROG_CYC),
        .PROT_CYC(PROT_CYC), .STEP_CYC(STEP_CYC), .ALLP_CYC(ALLP_CYC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .wdata(wdata),
        .prot(prot), .rdata(rdata), .busy(busy), .done(done), .fail(fail)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Scoreboard: the driver queues expected read values, the monitor compares.
    logic [ADDR_W-1:0] sb_a[$];
    logic [DATA_W-1:0] sb_e[$];
    string             sb_r[$];
    event              rd_ev;

    task automatic rd_expect(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string req);
        sb_a.push_back(a); sb_e.push_back(e); sb_r.push_back(req);
        @(negedge clk);
        addr = a;
        #1;
        -> rd_ev;
        #1;
    endtask

    initial begin
        forever begin
            @(rd_ev);
            if (sb_e.size() > 0) begin
                logic [ADDR_W-1:0] a;
                logic [DATA_W-1:0] e;
                string r;
                a = sb_a.pop_front(); e = sb_e.pop_front(); r = sb_r.pop_front();
                if (addr !== a) chk({r, " addr"}, addr, a);
                chk(r, rdata, e);
            end
        end
    end

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_prog(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        bus_wr(UA1, 16'h00AA); bus_wr(UA2, 16'h0055); bus_wr(UA1, 16'h00A0); bus_wr(a, d);
    endtask

    task automatic do_erase();
        bus_wr(UA1, 16'h00AA); bus_wr(UA2, 16'h0055); bus_wr(UA1, 16'h0080);
        bus_wr(UA1, 16'h00AA); bus_wr(UA2, 16'h0055); bus_wr(UA1, 16'h0010);
    endtask

    // Count busy cycles from now; on exit checks the done pulse.
    task automatic run_busy(input string req, output int n);
        n = 0;
        while (busy && n < 5000) begin
            n++;
            @(negedge clk);
        end
        chk({req, " done pulse"}, done, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 0); chk("R1 fail", fail, 0); chk("R1 done", done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7: erase with nothing protected
        do_erase();
        run_busy("R7", n);
        rd_expect(6'd0, 16'hFFFF, "R7 word0");
        rd_expect(6'd37, 16'hFFFF, "R7 word37");
        rd_expect(6'd63, 16'hFFFF, "R13 word63");

        // R2: plain program and exact busy length
        do_prog(6'd5, 16'h1234);
        run_busy("R2", n);
        chk("R2 busy cycles", n, PROG_CYC);
        chk("R2 fail", fail, 0);
        rd_expect(6'd5, 16'h1234, "R2 program");
        do_prog(6'd5, 16'h1230);
        run_busy("R2", n);
        rd_expect(6'd5, 16'h1230, "R2 clear-only program");

        // R3: address from the falling edge, data from the rising edge
        bus_wr(UA1, 16'h00AA); bus_wr(UA2, 16'h0055); bus_wr(UA1, 16'h00A0);
        @(negedge clk);
        addr = 6'd9; wdata = 16'hAAAA; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        addr = 6'd10; wdata = 16'h00FF;
        @(negedge clk);
        wr_n = 1'b1;
        repeat (2) @(negedge clk);
        run_busy("R3", n);
        rd_expect(6'd9, 16'h00FF, "R3 latched address");
        rd_expect(6'd10, 16'hFFFF, "R3 late address untouched");

        // R4: protected block
        prot = 4'b0010;
        do_prog(6'd20, 16'h0000);
        run_busy("R4", n);
        chk("R4 busy cycles", n, PROT_CYC);
        chk("R4 fail", fail, 0);
        rd_expect(6'd20, 16'hFFFF, "R4 protected word");
        prot = 4'b0000;

        // R5: setting a bit fails and locks
        do_prog(6'd5, 16'hFFFF);
        repeat (PROG_CYC + 6) @(negedge clk);
        chk("R5 fail", fail, 1);
        chk("R5 busy", busy, 1);

        // R6: only the reset code leaves the lock
        do_prog(6'd9, 16'h0000);
        chk("R6 still fail", fail, 1);
        bus_wr(6'd0, 16'h00F0);
        chk("R6 busy", busy, 0);
        chk("R6 fail", fail, 0);
        chk("R6 no done", done, 0);
        rd_expect(6'd9, 16'h00FF, "R6 ignored program");
        rd_expect(6'd5, 16'h1230, "R5 word kept");

        // R12: broken sequence
        bus_wr(UA1, 16'h00AA); bus_wr(UA2, 16'h0012); bus_wr(UA1, 16'h00A0); bus_wr(6'd40, 16'h0000);
        chk("R12 busy", busy, 0);
        rd_expect(6'd40, 16'hFFFF, "R12 word untouched");

        // R7 with protection, R11 commands during erase
        do_prog(6'd17, 16'hABCD);
        run_busy("R7", n);
        prot = 4'b0010;
        do_erase();
        do_prog(6'd3, 16'h0000);
        run_busy("R11", n);
        repeat (8) @(negedge clk);
        chk("R11 no restart", busy, 0);
        rd_expect(6'd3, 16'hFFFF, "R11 ignored program");
        rd_expect(6'd5, 16'hFFFF, "R7 erased");
        rd_expect(6'd17, 16'hABCD, "R7 protected kept");

        // R9: everything protected
        prot = 4'b1111;
        do_erase();
        run_busy("R9", n);
        chk("R9 busy cycles", n, ALLP_CYC);
        rd_expect(6'd17, 16'hABCD, "R9 unchanged");

        // R8 and R10: reset in the middle of the set-to-ones walk
        prot = 4'b0000;
        do_erase();
        repeat ((1 << ADDR_W) * STEP_CYC * 3 / 2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 busy in reset", busy, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_expect(6'd0, 16'hFFFF, "R8 low word erased");
        rd_expect(6'd63, 16'h0000, "R8 top word preprogrammed");
        do_erase();
        run_busy("R10", n);
        rd_expect(6'd63, 16'hFFFF, "R10 erase after abort");

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule